// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block turns single-step requests from a host-side controller into bus cycles on an 8-bit NAND flash bus that serves up to eight devices. A request names one step: latch a command byte, latch an address byte, write one data byte, read one data byte, or wait for the device to become ready. The block produces the active-low chip selects, the command and address latch strobes, the write and read strobes, and a data bus split into output, output-enable and input, ready for a pad-level tristate buffer. Every strobe width is a parameter counted in clock cycles.

Each device group shares one ready line. The sequencer synchronizes those lines and issues no strobe to a device whose line reports busy. After a program or erase confirm command it ignores the ready line for a set window, because the device takes some time to pull the line low. An external lock switch protects the configuration region. While the switch is low, any data write or program/erase setup command that the host marks as aimed at that region is refused at once and reported as an error, and no bus cycle reaches the flash.

A read burst is a series of single-byte read requests with no new address between them. Each read strobe moves the device on to its next column.

Top module: `nfs_bus_seq`

## Requirements
- R1: After reset `req_ready` is 1, all `chip_sel_n` bits are 1, both strobes are 1, both latch enables are 0, `io_oe` is 0 and `done` is 0. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while the block is idle. `done` is a one-cycle pulse that marks the end of each request.
- R2: Op code 0 (command) drives `req_data` with `io_oe` high and `cmd_latch` high for T_SETUP cycles, then holds `wr_strobe_n` low for T_WP cycles. After the rising edge it keeps the latch enable, the data and the chip select unchanged for T_HOLD cycles.
- R3: Op code 1 (address) has the same cycle shape as R2, with `addr_latch` high in place of `cmd_latch`.
- R4: Op code 2 (data write) has the same cycle shape as R2, with both latch enables low.
- R5: Op code 3 (data read) keeps `io_oe` low for at least one cycle before `rd_strobe_n` falls, and then holds `rd_strobe_n` low for T_RP cycles. It samples `io_in` at the end of that low phase and returns the byte on `rd_data` with `rd_valid` high in the `done` cycle. It then keeps `rd_strobe_n` high for T_REH cycles before `done`.
- R6: During any bus phase exactly the `chip_sel_n` bit chosen by `req_ce` is low. No bit is low while the block is idle.
- R7: Chip selects 0–3 depend on `flash_rdy[0]` and chip selects 4–7 on `flash_rdy[1]`. A request to a device does not strobe while that device's own line is low. A low line on the other group does not delay it.
- R8: After a command byte of 0x10 or 0xD0 has been latched, no request of any type leaves its wait phase for T_WB cycles. A busy pulse that starts inside this window is therefore honoured.
- R9: With `lock_n` low, a request with `req_cfg` = 1 that is either op 2, or op 0 with byte 0x80 or 0x60, ends with `done` and `done_err` high and produces no strobe. With `lock_n` high or `req_cfg` = 0, the same request runs normally and `done_err` is 0.
- R10: Op code 4 and above (wait) produces no strobe. It completes with `done` only once the selected device's ready line is high and the R8 window has expired.
- R11: `cmd_latch` and `addr_latch` are never high together. Both are low, and `io_oe` is 0, while `rd_strobe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 3 | Step: 0 command, 1 address, 2 write byte, 3 read byte, 4+ wait |
| req_ce | input | 3 | Target device index |
| req_data | input | 8 | Command, address or write byte |
| req_cfg | input | 1 | Request targets the protected configuration region |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request refused by the lock switch (with done) |
| rd_valid | output | 1 | rd_data holds a read byte (with done) |
| rd_data | output | 8 | Byte returned by a read step |
| chip_sel_n | output | 8 | Active-low device selects |
| cmd_latch | output | 1 | Bus holds a command byte |
| addr_latch | output | 1 | Bus holds an address byte |
| wr_strobe_n | output | 1 | Active-low write strobe; flash latches on rising edge |
| rd_strobe_n | output | 1 | Active-low read strobe; flash advances on falling edge |
| io_out | output | 8 | Data bus output value |
| io_oe | output | 1 | Data bus output enable |
| io_in | input | 8 | Data bus input value |
| flash_rdy | input | 2 | Ready lines per device group, low = busy |
| lock_n | input | 1 | Lock switch, low = configuration region protected |

## Verification
The hardest case to reach is a device that signals busy late, after a confirm command has been latched and after the next request has already been accepted. Only the R8 window keeps the sequencer from striking the device during that gap. The bench reproduces it by latching a confirm command and then lowering the group's ready line a few cycles after `done`, while a request to the same group waits. A bus monitor flags any strobe seen while the addressed group's line is low. The same timing is repeated against the other group, where the request has to finish while the first line is still held low.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

   typedef enum logic [2:0] {
      OP_CMD   = 3'd0,
      OP_ADDR  = 3'd1,
      OP_WDATA = 3'd2,
      OP_RDATA = 3'd3,
      OP_WAIT  = 3'd4
   } nfs_op_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WAIT,
      S_SETUP,
      S_WLOW,
      S_WHOLD,
      S_TURN,
      S_RLOW,
      S_RHIGH,
      S_FIN
   } nfs_state_e;

endpackage

// File: rtl/nfs_sync.sv
// Multi-stage level synchronizer; stage count chosen by parameter.
module nfs_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("nfs_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= {W{RST_VAL}};
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= {W{RST_VAL}};
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/nfs_phase_timer.sv
// Down counter that paces one bus phase; zero marks the last cycle.
module nfs_phase_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/nfs_busy_window.sv
// Window after a confirm command during which ready lines are not trusted.
module nfs_busy_window #(
   parameter int CYCLES = 10,
   localparam int CW    = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic clear
);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("nfs_busy_window: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (start)     cnt <= CW'(CYCLES);
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign clear = (cnt == '0);

endmodule

// File: rtl/nfs_wp_gate.sv
// Decides whether a request must be refused because the lock switch is low.
module nfs_wp_gate import nfs_pkg::*; #(
   parameter int          DW          = 8,
   parameter logic [DW-1:0] PROG_SETUP  = 8'h80,
   parameter logic [DW-1:0] ERASE_SETUP = 8'h60
) (
   input  logic          unlocked,
   input  logic          cfg,
   input  logic [2:0]    op,
   input  logic [DW-1:0] val,
   output logic          refuse
);

   logic is_write;

   always_comb begin
      is_write = 1'b0;
      if (op == 3'(OP_WDATA))
         is_write = 1'b1;
      else if (op == 3'(OP_CMD) && (val == PROG_SETUP || val == ERASE_SETUP))
         is_write = 1'b1;
   end

   assign refuse = !unlocked && cfg && is_write;

endmodule

// File: rtl/nfs_bus_seq.sv
module nfs_bus_seq import nfs_pkg::*; #(
   parameter int            NUM_CE        = 8,
   parameter int            NUM_RB        = 2,
   parameter int            DW            = 8,
   parameter int            TCW           = 6,
   parameter int            T_SETUP       = 2,
   parameter int            T_WP          = 3,
   parameter int            T_HOLD        = 2,
   parameter int            T_RP          = 3,
   parameter int            T_REH         = 2,
   parameter int            T_WB          = 10,
   parameter int            SYNC_STAGES   = 2,
   parameter logic [DW-1:0] PROG_SETUP    = 8'h80,
   parameter logic [DW-1:0] ERASE_SETUP   = 8'h60,
   parameter logic [DW-1:0] PROG_CONFIRM  = 8'h10,
   parameter logic [DW-1:0] ERASE_CONFIRM = 8'hD0,
   localparam int           CEW           = $clog2(NUM_CE),
   localparam int           CE_PER_RB     = NUM_CE / NUM_RB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_op,
   input  logic [CEW-1:0]    req_ce,
   input  logic [DW-1:0]     req_data,
   input  logic              req_cfg,
   output logic              done,
   output logic              done_err,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data,
   output logic [NUM_CE-1:0] chip_sel_n,
   output logic              cmd_latch,
   output logic              addr_latch,
   output logic              wr_strobe_n,
   output logic              rd_strobe_n,
   output logic [DW-1:0]     io_out,
   output logic              io_oe,
   input  logic [DW-1:0]     io_in,
   input  logic [NUM_RB-1:0] flash_rdy,
   input  logic              lock_n
);

   // ---------------- elaboration checks ----------------
   if (NUM_CE < 2 || NUM_RB < 1 || (NUM_CE % NUM_RB) != 0) begin : g_bad_ce
      $error("nfs_bus_seq: NUM_CE must be a multiple of NUM_RB");
   end
   if (T_SETUP < 1 || T_WP < 1 || T_HOLD < 1 || T_RP < 1 || T_REH < 1) begin : g_bad_t
      $error("nfs_bus_seq: every phase must last at least one cycle");
   end
   if (T_SETUP > 2**TCW || T_WP > 2**TCW || T_HOLD > 2**TCW ||
       T_RP > 2**TCW || T_REH > 2**TCW) begin : g_bad_tcw
      $error("nfs_bus_seq: TCW too narrow for a phase length");
   end
   if (T_WB < SYNC_STAGES + 2) begin : g_bad_wb
      $error("nfs_bus_seq: T_WB must cover the ready synchronizer delay");
   end

   // ---------------- state ----------------
   nfs_state_e     st, nxt;
   nfs_op_e        op_q;
   logic [CEW-1:0] ce_q;
   logic [DW-1:0]  val_q;
   logic           err_q;
   logic [DW-1:0]  rd_q;

   // ---------------- synchronized inputs ----------------
   logic [NUM_RB-1:0] rdy_s;
   logic              lock_s;

   nfs_sync #(.W(NUM_RB), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
      .clk(clk), .rst_n(rst_n), .d(flash_rdy), .q(rdy_s)
   );

   nfs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_lock_sync (
      .clk(clk), .rst_n(rst_n), .d(lock_n), .q(lock_s)
   );

   // ready line of the selected device's group
   logic [CEW-1:0] grp_idx;
   logic           rdy_ok;

   assign grp_idx = ce_q / CEW'(CE_PER_RB);

   always_comb begin
      rdy_ok = 1'b0;
      for (int g = 0; g < NUM_RB; g++)
         if (grp_idx == CEW'(g)) rdy_ok = rdy_s[g];
   end

   // ---------------- lock gate ----------------
   logic refuse;

   nfs_wp_gate #(.DW(DW), .PROG_SETUP(PROG_SETUP), .ERASE_SETUP(ERASE_SETUP)) u_gate (
      .unlocked(lock_s), .cfg(req_cfg), .op(req_op), .val(req_data), .refuse(refuse)
   );

   // ---------------- phase timer ----------------
   logic           tmr_load;
   logic [TCW-1:0] tmr_val;
   logic           tmr_zero;

   nfs_phase_timer #(.CW(TCW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
   );

   // ---------------- busy-ignore window ----------------
   logic win_start, win_clear;

   assign win_start = (st == S_WLOW) && tmr_zero && (op_q == OP_CMD) &&
                      (val_q == PROG_CONFIRM || val_q == ERASE_CONFIRM);

   nfs_busy_window #(.CYCLES(T_WB)) u_window (
      .clk(clk), .rst_n(rst_n), .start(win_start), .clear(win_clear)
   );

   // ---------------- sequencing ----------------
   always_comb begin
      nxt      = st;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st)
         S_IDLE:
            if (req_valid) nxt = refuse ? S_FIN : S_WAIT;
         S_WAIT:
            if (rdy_ok && win_clear) begin
               case (op_q)
                  OP_CMD, OP_ADDR, OP_WDATA: begin
                     nxt      = S_SETUP;
                     tmr_load = 1'b1;
                     tmr_val  = TCW'(T_SETUP - 1);
                  end
                  OP_RDATA: nxt = S_TURN;
                  default:  nxt = S_FIN;
               endcase
            end
         S_SETUP:
            if (tmr_zero) begin
               nxt      = S_WLOW;
               tmr_load = 1'b1;
               tmr_val  = TCW'(T_WP - 1);
            end
         S_WLOW:
            if (tmr_zero) begin
               nxt      = S_WHOLD;
               tmr_load = 1'b1;
               tmr_val  = TCW'(T_HOLD - 1);
            end
         S_WHOLD:
            if (tmr_zero) nxt = S_FIN;
         S_TURN: begin
            nxt      = S_RLOW;
            tmr_load = 1'b1;
            tmr_val  = TCW'(T_RP - 1);
         end
         S_RLOW:
            if (tmr_zero) begin
               nxt      = S_RHIGH;
               tmr_load = 1'b1;
               tmr_val  = TCW'(T_REH - 1);
            end
         S_RHIGH:
            if (tmr_zero) nxt = S_FIN;
         S_FIN:
            nxt = S_IDLE;
         default:
            nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         op_q  <= OP_WAIT;
         ce_q  <= '0;
         val_q <= '0;
         err_q <= 1'b0;
         rd_q  <= '0;
      end else begin
         st <= nxt;
         if (st == S_IDLE && req_valid) begin
            op_q  <= nfs_op_e'(req_op);
            ce_q  <= req_ce;
            val_q <= req_data;
            err_q <= refuse;
         end
         if (st == S_RLOW && tmr_zero) rd_q <= io_in;
      end
   end

   // ---------------- bus outputs ----------------
   logic wr_phase, bus_phase;

   assign wr_phase  = (st == S_SETUP) || (st == S_WLOW) || (st == S_WHOLD);
   assign bus_phase = wr_phase || (st == S_TURN) || (st == S_RLOW) || (st == S_RHIGH);

   for (genvar i = 0; i < NUM_CE; i++) begin : g_cs
      assign chip_sel_n[i] = !(bus_phase && (ce_q == CEW'(i)));
   end

   assign cmd_latch   = wr_phase && (op_q == OP_CMD);
   assign addr_latch  = wr_phase && (op_q == OP_ADDR);
   assign wr_strobe_n = (st != S_WLOW);
   assign rd_strobe_n = (st != S_RLOW);
   assign io_oe       = wr_phase;
   assign io_out      = wr_phase ? val_q : '0;

   // ---------------- host side ----------------
   assign req_ready = (st == S_IDLE);
   assign done      = (st == S_FIN);
   assign done_err  = (st == S_FIN) && err_q;
   assign rd_valid  = (st == S_FIN) && !err_q && (op_q == OP_RDATA);
   assign rd_data   = rd_q;

endmodule

// File: rtl/nfs_bus_seq_chk.sv
module nfs_bus_seq_chk #(
   parameter int NUM_CE = 8,
   parameter int DW     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic              done_err,
   input logic              rd_valid,
   input logic [NUM_CE-1:0] chip_sel_n,
   input logic              cmd_latch,
   input logic              addr_latch,
   input logic              wr_strobe_n,
   input logic              rd_strobe_n,
   input logic [DW-1:0]     io_out,
   input logic              io_oe,
   input logic              rdy_ok
);

   a_r11_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_latch && addr_latch));

   a_r11_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe_n |-> (!io_oe && !cmd_latch && !addr_latch));

   a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~chip_sel_n) <= 1);

   a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&chip_sel_n));

   a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_strobe_n) |-> ($stable(cmd_latch) && $stable(addr_latch) &&
                              $stable(io_out) && $stable(chip_sel_n) && io_oe));

   a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_strobe_n) |-> $past(!io_oe));

   a_r5_rdv_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (done && !done_err));

   a_r7_strobe_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_strobe_n) || $fell(rd_strobe_n) |-> $past(rdy_ok));

   a_r9_refused_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      done_err |-> (done && (&chip_sel_n) && wr_strobe_n && rd_strobe_n));

endmodule

bind nfs_bus_seq nfs_bus_seq_chk #(.NUM_CE(NUM_CE), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .done_err(done_err),
   .rd_valid(rd_valid), .chip_sel_n(chip_sel_n), .cmd_latch(cmd_latch),
   .addr_latch(addr_latch), .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
   .io_out(io_out), .io_oe(io_oe), .rdy_ok(rdy_ok)
);

// File: tb/sim_nfs_bus_seq.sv
`timescale 1ns/1ps
module sim_nfs_bus_seq;

   localparam int T_SETUP = 2, T_WP = 3, T_HOLD = 2, T_RP = 3, T_REH = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [2:0] req_op = '0;
   logic [2:0] req_ce = '0;
   logic [7:0] req_data = '0;
   logic       req_cfg = 1'b0;
   logic       done, done_err, rd_valid;
   logic [7:0] rd_data;
   logic [7:0] chip_sel_n;
   logic       cmd_latch, addr_latch, wr_strobe_n, rd_strobe_n;
   logic [7:0] io_out;
   logic       io_oe;
   logic [7:0] io_in = '0;
   logic [1:0] flash_rdy = 2'b11;
   logic       lock_n = 1'b1;

   always #2 clk = ~clk;

   nfs_bus_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_ce(req_ce), .req_data(req_data), .req_cfg(req_cfg),
      .done(done), .done_err(done_err), .rd_valid(rd_valid), .rd_data(rd_data),
      .chip_sel_n(chip_sel_n), .cmd_latch(cmd_latch), .addr_latch(addr_latch),
      .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n), .io_out(io_out),
      .io_oe(io_oe), .io_in(io_in), .flash_rdy(flash_rdy), .lock_n(lock_n)
   );

   int checks = 0, fails = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] flash_byte(input int col);
      return 8'((col * 29) + 8'h5A);
   endfunction

   function automatic int sel_idx(input logic [7:0] cs);
      for (int i = 0; i < 8; i++) if (!cs[i]) return i;
      return -1;
   endfunction

   function automatic bit exp_refuse(input logic [2:0] op, input logic [7:0] v,
                                     input bit cfg, input bit lk);
      if (lk || !cfg) return 0;
      return (op == 3'd2) || (op == 3'd0 && (v == 8'h80 || v == 8'h60));
   endfunction

   // ---------------- bus monitor and flash model ----------------
   logic we_p = 1'b1, re_p = 1'b1, oe_p = 1'b0;
   int   su = 0, wl = 0, ho = 0, rl = 0;
   bit   rose = 0;
   int   wcnt = 0, rcnt = 0, viol = 0, gap_bad = 0;
   logic l_cle, l_ale;
   logic [7:0] l_dq;
   int   l_ce;
   int   model_col = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (io_oe && !oe_p) begin
            su = 1; wl = 0; ho = 0; rose = 0;
         end else if (io_oe) begin
            if (!wr_strobe_n) wl++;
            else if (!we_p) begin
               rose = 1; ho = 1; wcnt++;
               l_cle = cmd_latch; l_ale = addr_latch; l_dq = io_out;
               l_ce = sel_idx(chip_sel_n);
               if (addr_latch) model_col = 0;
            end else if (rose) ho++;
            else su++;
         end
         if (re_p && !rd_strobe_n) begin
            rl = 1; rcnt++;
            if (oe_p) gap_bad++;
            io_in <= flash_byte(model_col);
            model_col++;
         end else if (!rd_strobe_n) rl++;
         if ((!wr_strobe_n || !rd_strobe_n) && sel_idx(chip_sel_n) >= 0 &&
             !flash_rdy[sel_idx(chip_sel_n) / 4])
            viol++;
      end
      we_p = wr_strobe_n; re_p = rd_strobe_n; oe_p = io_oe;
   end

   // ---------------- request driver ----------------
   bit         r_err, r_rdv;
   logic [7:0] r_data;
   int         r_t;

   task automatic do_op(input logic [2:0] op, input int ce, input logic [7:0] v, input bit cfg);
      int n;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_op = op; req_ce = 3'(ce); req_data = v; req_cfg = cfg; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!done && n < 3000) begin @(negedge clk); n++; end
      if (!done) chk(0, "R1 done timeout", 0, 1);
      r_err = done_err; r_rdv = rd_valid; r_data = rd_data; r_t = cyc;
   endtask

   task automatic busy_pulse(input int g, input int dly, input int len);
      fork
         begin
            repeat (dly) @(negedge clk);
            flash_rdy[g] = 1'b0;
            repeat (len) @(negedge clk);
            flash_rdy[g] = 1'b1;
         end
      join_none
   endtask

   task automatic chk_write(input string tag, input bit c, input bit a, input logic [7:0] v, input int ce);
      chk(l_cle == c && l_ale == a, {tag, " latch enables"}, {l_cle, l_ale}, {c, a});
      chk(l_dq == v, {tag, " latched byte"}, l_dq, v);
      chk(l_ce == ce, {tag, " selected device"}, l_ce, ce);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   // ---------------- stimulus ----------------
   int exp_col = 0;

   initial begin
      int w0, r0, rel;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready && chip_sel_n == 8'hFF && wr_strobe_n && rd_strobe_n &&
          !cmd_latch && !addr_latch && !io_oe && !done, "R1 reset state",
          {req_ready, chip_sel_n, wr_strobe_n, rd_strobe_n, cmd_latch, addr_latch, io_oe, done},
          {1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 command cycle shape
      do_op(3'd0, 3, 8'h00, 0);
      chk_write("R2", 1, 0, 8'h00, 3);
      chk(su == T_SETUP, "R2 setup cycles", su, T_SETUP);
      chk(wl == T_WP, "R2 strobe low cycles", wl, T_WP);
      chk(ho == T_HOLD, "R2 hold cycles", ho, T_HOLD);
      chk(!r_err, "R2 no error", r_err, 0);

      // R3 address cycle
      do_op(3'd1, 3, 8'h00, 0); exp_col = 0;
      chk_write("R3", 0, 1, 8'h00, 3);
      chk(wl == T_WP && su == T_SETUP, "R3 timing", {su, wl}, {T_SETUP, T_WP});

      // R5 read burst of four
      for (int k = 0; k < 4; k++) begin
         do_op(3'd3, 3, 8'h00, 0);
         chk(r_rdv && r_data == flash_byte(exp_col), "R5 read byte", r_data, flash_byte(exp_col));
         chk(rl == T_RP, "R5 read strobe low", rl, T_RP);
         exp_col++;
      end
      chk(gap_bad == 0, "R5 io_oe low before read strobe", gap_bad, 0);

      // R4 write data byte
      do_op(3'd2, 6, 8'hA7, 0);
      chk_write("R4", 0, 0, 8'hA7, 6);

      // R9 lock switch refusals
      lock_n = 1'b0; repeat (4) @(negedge clk);
      w0 = wcnt; r0 = rcnt;
      do_op(3'd0, 2, 8'h60, 1);
      chk(r_err && wcnt == w0, "R9 erase setup refused", {r_err, wcnt}, {1'b1, w0});
      do_op(3'd2, 2, 8'h11, 1);
      chk(r_err && wcnt == w0 && rcnt == r0, "R9 data write refused", {r_err, wcnt}, {1'b1, w0});
      do_op(3'd0, 2, 8'h80, 0);
      chk(!r_err && wcnt == w0 + 1, "R9 outside region allowed", {r_err, wcnt}, {1'b0, w0 + 1});
      lock_n = 1'b1; repeat (4) @(negedge clk);
      do_op(3'd0, 2, 8'h80, 1);
      chk(!r_err && l_dq == 8'h80, "R9 unlocked allowed", {r_err, l_dq}, {1'b0, 8'h80});

      // R8 late busy after confirm, same group (R7)
      do_op(3'd0, 1, 8'h10, 0);
      busy_pulse(0, 4, 40);
      rel = cyc + 44;
      do_op(3'd2, 2, 8'h3C, 0);
      chk(viol == 0, "R8 no strobe while busy inside window", viol, 0);
      chk(r_t >= rel, "R7 same group waits for ready", r_t, rel);
      chk_write("R7", 0, 0, 8'h3C, 2);

      // R7 other group proceeds while group 0 is busy
      do_op(3'd0, 0, 8'hD0, 0);
      busy_pulse(0, 4, 300);
      do_op(3'd0, 6, 8'h70, 0);
      chk(flash_rdy[0] == 1'b0, "R7 other group not delayed", flash_rdy[0], 0);
      chk(viol == 0, "R7 no strobe to busy group", viol, 0);
      while (!flash_rdy[0]) @(negedge clk);

      // R10 wait step
      w0 = wcnt; r0 = rcnt;
      busy_pulse(1, 1, 30);
      repeat (3) @(negedge clk);
      rel = cyc + 28;
      do_op(3'd4, 7, 8'h00, 0);
      chk(r_t >= rel && flash_rdy[1], "R10 wait completes after ready", r_t, rel);
      chk(wcnt == w0 && rcnt == r0, "R10 no strobes", wcnt, w0);
      do_op(3'd5, 1, 8'h00, 0);
      chk(wcnt == w0 && rcnt == r0 && !r_err, "R10 op 5 acts as wait", wcnt, w0);

      // random mix
      void'($urandom(32'h1D2C3B4A));
      for (int k = 0; k < 150; k++) begin
         logic [2:0] op; logic [7:0] v; int ce; bit cfg, lk, rf;
         op = 3'($urandom_range(0, 4)); v = 8'($urandom); ce = $urandom_range(0, 7);
         cfg = 1'($urandom); lk = 1'($urandom);
         if ($urandom_range(0, 3) == 0) v = ($urandom_range(0, 1) != 0) ? 8'h80 : 8'h60;
         if (lock_n != lk) begin lock_n = lk; repeat (4) @(negedge clk); end
         rf = exp_refuse(op, v, cfg, lk);
         w0 = wcnt; r0 = rcnt;
         do_op(op, ce, v, cfg);
         chk(r_err == rf, "R9 random refuse flag", r_err, rf);
         if (rf) chk(wcnt == w0 && rcnt == r0, "R9 random refused bus idle", wcnt, w0);
         else if (op <= 3'd2) begin
            if (op == 3'd1) exp_col = 0;
            chk_write(op == 3'd0 ? "R2 random" : (op == 3'd1 ? "R3 random" : "R4 random"),
                      op == 3'd0, op == 3'd1, v, ce);
         end else if (op == 3'd3) begin
            chk(r_rdv && r_data == flash_byte(exp_col), "R5 random read", r_data, flash_byte(exp_col));
            exp_col++;
         end else chk(wcnt == w0 && rcnt == r0, "R10 random wait", wcnt, w0);
      end
      chk(viol == 0, "R7 no strobe while busy overall", viol, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule